// File: doc/BRIEF.md
# Memory-Mapped Burst Length Adapter

This block sits between a memory-mapped host that issues long incrementing bursts and an agent that accepts only shorter ones. Each host burst of N words at byte address A is reissued to the agent as a chain of sub-bursts. Each sub-burst is as long as the agent allows, except the last, which carries whatever is left. Together they touch A, A+W, A+2W … (W = data width in bytes) exactly once, in increasing order. The block regenerates the agent-side address and burst count for every sub-burst. Write data passes straight through beat by beat, and read data returns to the host unchanged and in order.

Write bursts keep the host's beat-by-beat flow. The command of a new sub-burst goes out together with its first data beat, and the agent's waitrequest stalls the host directly. A read burst is a single host command. The adapter holds that command with waitrequest while it issues the read sub-bursts one after another, and releases it in the cycle the last sub-burst is accepted. The host then simply counts its N returning data-valid beats. When the agent maximum covers the largest host burst, the parameterisation turns the block into plain wires. A maximum of one turns every host burst into single-word transfers.

Top module: `bla_burst_split`

## Requirements
- R1: A host burst whose burst count is at most AGENT_MAX reaches the agent as a single burst with the host's own address and burst count.
- R2: Every burst count presented to the agent with a read or write command is between 1 and AGENT_MAX.
- R3: A host burst of N words is issued as ceil(N/AGENT_MAX) agent bursts; each has length min(remaining, AGENT_MAX), so only the final one can be shorter.
- R4: Sub-burst k of a host burst at byte address A starts at A + k·AGENT_MAX·(DATA_W/8), and the agent accesses every word address of the host range exactly once, in ascending order.
- R5: Write data is forwarded beat by beat; the first beat of each write sub-burst carries that sub-burst's address and burst count, and each word lands at its own address.
- R6: While the agent asserts waitrequest during a write, the host sees waitrequest, and the agent-side address and burst count stay unchanged.
- R7: A long read command is held at the host by waitrequest until the agent accepts its last sub-burst; at host release that sub-burst ends exactly at the end of the host range.
- R8: Read data-valid beats from the agent reach the host in the order they arrive, so the host's N beats are the words A, A+W, … in order.
- R9: With AGENT_MAX = 1, every host burst becomes N single-word agent transfers at consecutive addresses.
- R10: After reset, with no host read or write, the agent sees neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_address | input | AW | Host byte address of burst start |
| h_burstcount | input | HBC_W | Host burst length in words |
| h_read | input | 1 | Host read command |
| h_write | input | 1 | Host write beat |
| h_writedata | input | DW | Host write data |
| h_waitrequest | output | 1 | Stall to host |
| h_readdata | output | DW | Read data to host |
| h_readdatavalid | output | 1 | Read data valid to host |
| a_address | output | AW | Agent byte address of sub-burst start |
| a_burstcount | output | ABC_W | Agent sub-burst length in words |
| a_read | output | 1 | Agent read command |
| a_write | output | 1 | Agent write beat |
| a_writedata | output | DW | Write data to agent |
| a_waitrequest | input | 1 | Stall from agent |
| a_readdata | input | DW | Read data from agent |
| a_readdatavalid | input | 1 | Read data valid from agent |

## Verification
The assertions check several properties on every cycle. No agent command carries a burst count of zero or one above the maximum. A short read leaves unchanged. A stalled write keeps its command fields steady and stalls the host. Consecutive read sub-bursts of one held command advance by exactly the previous length. A released read command ends at the host range's end. The bench's scenarios are needed to show the whole-burst behaviour: the exact number and lengths of sub-bursts, every word of a range written or read once in ascending order with the right data, and the single-word split of the second instance with a maximum of one. These scenarios run against a behavioural agent with random stalls.

// File: rtl/bla_pkg.sv
package bla_pkg;
    // Classification of a write beat relative to the sub-burst chain.
    typedef enum logic [1:0] {
        SEG_OPEN = 2'd0,   // first beat of a fresh host burst
        SEG_NEXT = 2'd1,   // first beat of a follow-on sub-burst
        SEG_CONT = 2'd2    // inside an already opened sub-burst
    } seg_kind_e;
endpackage

// File: rtl/bla_sub_len.sv
module bla_sub_len #(
    parameter int HBC_W     = 8,
    parameter int ABC_W     = 3,
    parameter int AGENT_MAX = 4
) (
    input  logic [HBC_W-1:0] left,
    output logic [ABC_W-1:0] len,
    output logic             is_last
);
    localparam logic [HBC_W-1:0] MAX_H = HBC_W'(AGENT_MAX);
    localparam logic [ABC_W-1:0] MAX_A = ABC_W'(AGENT_MAX);

    always_comb begin
        is_last = (left <= MAX_H);
        len     = is_last ? ABC_W'(left) : MAX_A;
    end
endmodule

// File: rtl/bla_wr_split.sv
module bla_wr_split
    import bla_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int HBC_W     = 8,
    parameter int ABC_W     = 3,
    parameter int AGENT_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_write,
    input  logic [AW-1:0]    h_address,
    input  logic [HBC_W-1:0] h_burstcount,
    input  logic             a_waitrequest,
    output logic [AW-1:0]    a_address,
    output logic [ABC_W-1:0] a_burstcount,
    output logic             busy
);
    localparam int SH = $clog2(DW / 8);

    typedef struct packed {
        logic             active;
        logic [AW-1:0]    addr;
        logic [ABC_W-1:0] bc;
        logic [ABC_W-1:0] sub_left;
        logic [HBC_W-1:0] tot_left;
    } wr_st_t;

    wr_st_t            st_d, st_q;
    seg_kind_e         kind;
    logic [HBC_W-1:0]  len_in;
    logic [ABC_W-1:0]  len_out;
    logic              len_last;
    logic [HBC_W-1:0]  eff_tot;
    logic [AW-1:0]     eff_addr;
    logic [ABC_W-1:0]  eff_bc;
    logic [ABC_W-1:0]  eff_sub;

    bla_sub_len #(
        .HBC_W(HBC_W), .ABC_W(ABC_W), .AGENT_MAX(AGENT_MAX)
    ) u_len (
        .left(len_in), .len(len_out), .is_last(len_last)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.active)            kind = SEG_OPEN;
        else if (st_q.sub_left == '0) kind = SEG_NEXT;
        else                          kind = SEG_CONT;

        len_in = (kind == SEG_OPEN) ? h_burstcount : st_q.tot_left;

        case (kind)
            SEG_OPEN: begin
                eff_tot  = h_burstcount;
                eff_addr = h_address;
                eff_bc   = len_out;
                eff_sub  = len_out;
            end
            SEG_NEXT: begin
                eff_tot  = st_q.tot_left;
                eff_addr = st_q.addr + (AW'(st_q.bc) << SH);
                eff_bc   = len_out;
                eff_sub  = len_out;
            end
            default: begin
                eff_tot  = st_q.tot_left;
                eff_addr = st_q.addr;
                eff_bc   = st_q.bc;
                eff_sub  = st_q.sub_left;
            end
        endcase

        if (h_write && !a_waitrequest) begin
            st_d.active   = (eff_tot != HBC_W'(1));
            st_d.addr     = eff_addr;
            st_d.bc       = eff_bc;
            st_d.sub_left = eff_sub - ABC_W'(1);
            st_d.tot_left = eff_tot - HBC_W'(1);
        end

        a_address    = eff_addr;
        a_burstcount = eff_bc;
        busy         = st_q.active;
    end

    // len_last is not needed on the write side: the chain ends by total count.
    logic unused_last;
    assign unused_last = len_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bla_rd_split.sv
module bla_rd_split #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int HBC_W     = 8,
    parameter int ABC_W     = 3,
    parameter int AGENT_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             h_read,
    input  logic [AW-1:0]    h_address,
    input  logic [HBC_W-1:0] h_burstcount,
    input  logic             a_waitrequest,
    output logic             a_read,
    output logic [AW-1:0]    a_address,
    output logic [ABC_W-1:0] a_burstcount,
    output logic             h_waitrequest
);
    localparam int SH = $clog2(DW / 8);

    typedef struct packed {
        logic [HBC_W-1:0] off;   // words already issued for the held command
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [HBC_W-1:0] left;
    logic [ABC_W-1:0] len_out;
    logic             len_last;

    bla_sub_len #(
        .HBC_W(HBC_W), .ABC_W(ABC_W), .AGENT_MAX(AGENT_MAX)
    ) u_len (
        .left(left), .len(len_out), .is_last(len_last)
    );

    always_comb begin
        st_d          = st_q;
        left          = h_burstcount - st_q.off;
        a_read        = h_read && enable;
        a_address     = h_address + (AW'(st_q.off) << SH);
        a_burstcount  = len_out;
        h_waitrequest = !enable || a_waitrequest || !len_last;
        if (a_read && !a_waitrequest) begin
            st_d.off = len_last ? '0 : (st_q.off + HBC_W'(AGENT_MAX));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bla_burst_split.sv
module bla_burst_split #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int HBC_W     = 8,
    parameter int AGENT_MAX = 4,
    localparam int ABC_W    = $clog2(AGENT_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    h_address,
    input  logic [HBC_W-1:0] h_burstcount,
    input  logic             h_read,
    input  logic             h_write,
    input  logic [DW-1:0]    h_writedata,
    output logic             h_waitrequest,
    output logic [DW-1:0]    h_readdata,
    output logic             h_readdatavalid,
    output logic [AW-1:0]    a_address,
    output logic [ABC_W-1:0] a_burstcount,
    output logic             a_read,
    output logic             a_write,
    output logic [DW-1:0]    a_writedata,
    input  logic             a_waitrequest,
    input  logic [DW-1:0]    a_readdata,
    input  logic             a_readdatavalid
);
    localparam int HOST_MAX = 2 ** (HBC_W - 1);

    // Data paths are never altered: only command fields are rewritten.
    assign a_writedata     = h_writedata;
    assign h_readdata      = a_readdata;
    assign h_readdatavalid = a_readdatavalid;

    if (AGENT_MAX >= HOST_MAX) begin : g_pass
        assign a_address     = h_address;
        assign a_burstcount  = ABC_W'(h_burstcount);
        assign a_read        = h_read;
        assign a_write       = h_write;
        assign h_waitrequest = a_waitrequest;
    end else begin : g_split
        logic             wr_busy;
        logic             wr_own;
        logic [AW-1:0]    wr_addr;
        logic [AW-1:0]    rd_addr;
        logic [ABC_W-1:0] wr_bc;
        logic [ABC_W-1:0] rd_bc;
        logic             rd_go;
        logic             rd_wait;

        assign wr_own = h_write || wr_busy;

        bla_wr_split #(
            .AW(AW), .DW(DW), .HBC_W(HBC_W), .ABC_W(ABC_W), .AGENT_MAX(AGENT_MAX)
        ) u_wr (
            .clk(clk), .rst_n(rst_n),
            .h_write(h_write), .h_address(h_address), .h_burstcount(h_burstcount),
            .a_waitrequest(a_waitrequest),
            .a_address(wr_addr), .a_burstcount(wr_bc), .busy(wr_busy)
        );

        bla_rd_split #(
            .AW(AW), .DW(DW), .HBC_W(HBC_W), .ABC_W(ABC_W), .AGENT_MAX(AGENT_MAX)
        ) u_rd (
            .clk(clk), .rst_n(rst_n), .enable(!wr_own),
            .h_read(h_read), .h_address(h_address), .h_burstcount(h_burstcount),
            .a_waitrequest(a_waitrequest),
            .a_read(rd_go), .a_address(rd_addr), .a_burstcount(rd_bc),
            .h_waitrequest(rd_wait)
        );

        assign a_write       = h_write;
        assign a_read        = rd_go;
        assign a_address     = wr_own ? wr_addr : rd_addr;
        assign a_burstcount  = wr_own ? wr_bc : rd_bc;
        assign h_waitrequest = wr_own ? a_waitrequest : rd_wait;
    end
endmodule

// File: rtl/bla_burst_split_chk.sv
module bla_burst_split_chk #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int HBC_W     = 8,
    parameter int AGENT_MAX = 4,
    parameter int ABC_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    h_address,
    input logic [HBC_W-1:0] h_burstcount,
    input logic             h_read,
    input logic             h_write,
    input logic             h_waitrequest,
    input logic [AW-1:0]    a_address,
    input logic [ABC_W-1:0] a_burstcount,
    input logic             a_read,
    input logic             a_write,
    input logic             a_waitrequest
);
    localparam int SH = $clog2(DW / 8);
    localparam logic [ABC_W-1:0] MAX_A = ABC_W'(AGENT_MAX);
    localparam logic [HBC_W-1:0] MAX_H = HBC_W'(AGENT_MAX);

    AST_BC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (a_read || a_write) |-> (a_burstcount != '0 && a_burstcount <= MAX_A)); // R2

    AST_SHORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_read && !h_write && h_burstcount <= MAX_H) |->
        (a_read && HBC_W'(a_burstcount) == h_burstcount && a_address == h_address)); // R1

    AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (h_write && a_waitrequest) |-> h_waitrequest); // R6

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_write && a_waitrequest) |=>
        (!a_write || ($stable(a_address) && $stable(a_burstcount)))); // R6

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_read && a_read && !a_waitrequest && h_waitrequest) |=>
        (a_read && a_address == $past(a_address) + (AW'($past(a_burstcount)) << SH))); // R4

    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_read && !h_write && !h_waitrequest) |->
        (a_read && a_address + (AW'(a_burstcount) << SH) ==
                   h_address + (AW'(h_burstcount) << SH))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_read && !h_write) |-> (!a_read && !a_write)); // R10
endmodule

bind bla_burst_split bla_burst_split_chk #(
    .AW(AW), .DW(DW), .HBC_W(HBC_W), .AGENT_MAX(AGENT_MAX), .ABC_W(ABC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .h_address(h_address), .h_burstcount(h_burstcount),
    .h_read(h_read), .h_write(h_write), .h_waitrequest(h_waitrequest),
    .a_address(a_address), .a_burstcount(a_burstcount),
    .a_read(a_read), .a_write(a_write), .a_waitrequest(a_waitrequest)
);

// File: tb/bla_agent_model.sv
module bla_agent_model #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BCW   = 3,
    parameter int MAX   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall_en,
    input  logic [AW-1:0]  a_address,
    input  logic [BCW-1:0] a_burstcount,
    input  logic           a_read,
    input  logic           a_write,
    input  logic [DW-1:0]  a_writedata,
    output logic           a_waitrequest,
    output logic [DW-1:0]  a_readdata,
    output logic           a_readdatavalid
);
    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] cmd_addr [0:1023];
    int            cmd_bc   [0:1023];
    logic          cmd_wr   [0:1023];
    logic [AW-1:0] beat_addr [0:1023];
    logic [DW-1:0] beat_data [0:1023];
    int            ncmd, nbeat, viol;

    logic [15:0]   lfsr;
    int            wr_left;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] q_addr [0:63];
    int            q_bc   [0:63];
    int            q_head, q_tail;
    int            rsp_left;
    logic [AW-1:0] rsp_addr;
    logic [AW-1:0] ua;

    assign a_waitrequest = stall_en & lfsr[0];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 ^ (i * 7);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= 16'hACE1; ncmd <= 0; nbeat <= 0; viol <= 0;
            wr_left <= 0; wr_addr <= '0; q_head <= 0; q_tail <= 0;
            rsp_left <= 0; rsp_addr <= '0; a_readdatavalid <= 1'b0; a_readdata <= '0;
        end else begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a_readdatavalid <= 1'b0;
            if (a_write && !a_waitrequest) begin
                if (wr_left == 0) begin
                    ua = a_address;
                    cmd_addr[ncmd] <= a_address; cmd_bc[ncmd] <= int'(a_burstcount);
                    cmd_wr[ncmd] <= 1'b1; ncmd <= ncmd + 1;
                    if (a_burstcount == 0 || int'(a_burstcount) > MAX) viol <= viol + 1;
                    wr_left <= int'(a_burstcount) - 1;
                end else begin
                    ua = wr_addr;
                    wr_left <= wr_left - 1;
                end
                wr_addr <= ua + 4;
                mem[ua[9:2]] <= a_writedata;
                beat_addr[nbeat] <= ua; beat_data[nbeat] <= a_writedata;
                nbeat <= nbeat + 1;
            end
            if (a_read && !a_waitrequest) begin
                cmd_addr[ncmd] <= a_address; cmd_bc[ncmd] <= int'(a_burstcount);
                cmd_wr[ncmd] <= 1'b0; ncmd <= ncmd + 1;
                if (a_burstcount == 0 || int'(a_burstcount) > MAX) viol <= viol + 1;
                q_addr[q_tail % 64] <= a_address; q_bc[q_tail % 64] <= int'(a_burstcount);
                q_tail <= q_tail + 1;
            end
            if (rsp_left > 0) begin
                a_readdatavalid <= 1'b1;
                a_readdata <= mem[rsp_addr[9:2]];
                beat_addr[nbeat] <= rsp_addr; beat_data[nbeat] <= mem[rsp_addr[9:2]];
                nbeat <= nbeat + 1;
                rsp_left <= rsp_left - 1;
                rsp_addr <= rsp_addr + 4;
            end else if (q_head != q_tail) begin
                rsp_left <= q_bc[q_head % 64];
                rsp_addr <= q_addr[q_head % 64];
                q_head <= q_head + 1;
            end
        end
    end
endmodule

// File: tb/bla_burst_split_tb_top.sv
module bla_burst_split_tb_top;
    localparam int AW = 32, DW = 32, HBC_W = 8;
    localparam int MAX0 = 4, MAX1 = 1;
    localparam int BCW0 = $clog2(MAX0) + 1, BCW1 = $clog2(MAX1) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic             sel = 1'b0, stall_en = 1'b0;
    logic [AW-1:0]    hb_addr = '0;
    logic [HBC_W-1:0] hb_bc = '0;
    logic             hb_read = 1'b0, hb_write = 1'b0;
    logic [DW-1:0]    hb_wdata = '0;

    logic w0, w1, rdv0, rdv1;
    logic [DW-1:0] rd0, rd1;
    logic [AW-1:0] aa0, aa1;
    logic [BCW0-1:0] ab0;
    logic [BCW1-1:0] ab1;
    logic ar0, ar1, aw0, aw1, awt0, awt1, ardv0, ardv1;
    logic [DW-1:0] awd0, awd1, ard0, ard1;

    bla_burst_split #(.AW(AW), .DW(DW), .HBC_W(HBC_W), .AGENT_MAX(MAX0)) dut_i (
        .clk(clk), .rst_n(rst_n), .h_address(hb_addr), .h_burstcount(hb_bc),
        .h_read(hb_read && !sel), .h_write(hb_write && !sel), .h_writedata(hb_wdata),
        .h_waitrequest(w0), .h_readdata(rd0), .h_readdatavalid(rdv0),
        .a_address(aa0), .a_burstcount(ab0), .a_read(ar0), .a_write(aw0),
        .a_writedata(awd0), .a_waitrequest(awt0), .a_readdata(ard0), .a_readdatavalid(ardv0));
    bla_agent_model #(.AW(AW), .DW(DW), .BCW(BCW0), .MAX(MAX0)) m0 (
        .clk(clk), .rst_n(rst_n), .stall_en(stall_en && !sel), .a_address(aa0),
        .a_burstcount(ab0), .a_read(ar0), .a_write(aw0), .a_writedata(awd0),
        .a_waitrequest(awt0), .a_readdata(ard0), .a_readdatavalid(ardv0));

    bla_burst_split #(.AW(AW), .DW(DW), .HBC_W(HBC_W), .AGENT_MAX(MAX1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .h_address(hb_addr), .h_burstcount(hb_bc),
        .h_read(hb_read && sel), .h_write(hb_write && sel), .h_writedata(hb_wdata),
        .h_waitrequest(w1), .h_readdata(rd1), .h_readdatavalid(rdv1),
        .a_address(aa1), .a_burstcount(ab1), .a_read(ar1), .a_write(aw1),
        .a_writedata(awd1), .a_waitrequest(awt1), .a_readdata(ard1), .a_readdatavalid(ardv1));
    bla_agent_model #(.AW(AW), .DW(DW), .BCW(BCW1), .MAX(MAX1)) m1 (
        .clk(clk), .rst_n(rst_n), .stall_en(stall_en && sel), .a_address(aa1),
        .a_burstcount(ab1), .a_read(ar1), .a_write(aw1), .a_writedata(awd1),
        .a_waitrequest(awt1), .a_readdata(ard1), .a_readdatavalid(ardv1));

    logic obs_wait, obs_rdv, obs_awt;
    logic [DW-1:0] obs_rdata;
    assign obs_wait  = sel ? w1 : w0;
    assign obs_rdv   = sel ? rdv1 : rdv0;
    assign obs_rdata = sel ? rd1 : rd0;
    assign obs_awt   = sel ? awt1 : awt0;

    int n_cmp = 0, n_bad = 0, cyc = 0, stall_err = 0;
    logic [DW-1:0] exp0 [0:255];
    logic [DW-1:0] exp1 [0:255];
    logic [DW-1:0] rbuf [0:2047];
    int rcnt = 0;

    always @(negedge clk) begin
        if (obs_rdv) begin rbuf[rcnt % 2048] = obs_rdata; rcnt = rcnt + 1; end
        if ((hb_write || hb_read) && obs_awt && !obs_wait) stall_err = stall_err + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cur_max();  return sel ? MAX1 : MAX0; endfunction
    function automatic int cmd_n();    return sel ? m1.ncmd : m0.ncmd; endfunction
    function automatic int beat_n();   return sel ? m1.nbeat : m0.nbeat; endfunction
    function automatic longint c_addr(int k); return sel ? m1.cmd_addr[k] : m0.cmd_addr[k]; endfunction
    function automatic int c_bc(int k); return sel ? m1.cmd_bc[k] : m0.cmd_bc[k]; endfunction
    function automatic bit c_wr(int k); return sel ? m1.cmd_wr[k] : m0.cmd_wr[k]; endfunction
    function automatic longint b_addr(int k); return sel ? m1.beat_addr[k] : m0.beat_addr[k]; endfunction
    function automatic longint b_data(int k); return sel ? m1.beat_data[k] : m0.beat_data[k]; endfunction
    function automatic logic [DW-1:0] exp_word(logic [AW-1:0] a);
        return sel ? exp1[a[9:2]] : exp0[a[9:2]];
    endfunction

    // Sub-burst command log check shared by reads and writes (R3, R4)
    task automatic chk_cmds(int c0, logic [AW-1:0] base, int bc, bit is_wr, string tag);
        int mx = cur_max();
        int nsub = (bc + mx - 1) / mx;
        chk(cmd_n() - c0 == nsub, "R3", {tag, " sub-burst count"}, cmd_n() - c0, nsub);
        for (int k = 0; k < nsub && k < cmd_n() - c0; k++) begin
            int exp_len = (bc - k * mx) < mx ? (bc - k * mx) : mx;
            chk(c_addr(c0 + k) == longint'(base + 4 * mx * k), "R4", {tag, " sub-burst address"},
                c_addr(c0 + k), base + 4 * mx * k);
            chk(c_bc(c0 + k) == exp_len, "R3", {tag, " sub-burst length"}, c_bc(c0 + k), exp_len);
            chk(c_wr(c0 + k) == is_wr, "R5", {tag, " command kind"}, c_wr(c0 + k), is_wr);
        end
    endtask

    task automatic do_write(bit s, logic [AW-1:0] base, int bc, bit stall, string tag);
        int c0, b0;
        @(posedge clk); #1;
        sel = s; stall_en = stall;
        c0 = cmd_n(); b0 = beat_n();
        for (int i = 0; i < bc; i++) begin
            hb_write = 1'b1; hb_addr = base; hb_bc = HBC_W'(bc);
            hb_wdata = 32'h5A00_0000 + base + i;
            forever begin @(negedge clk); if (!obs_wait) break; end
            if (s) exp1[(base[9:2] + i) % 256] = hb_wdata;
            else   exp0[(base[9:2] + i) % 256] = hb_wdata;
            @(posedge clk); #1;
        end
        hb_write = 1'b0;
        repeat (3) @(negedge clk);
        chk_cmds(c0, base, bc, 1'b1, tag);
        chk(beat_n() - b0 == bc, "R5", {tag, " beat count"}, beat_n() - b0, bc);
        for (int i = 0; i < bc && i < beat_n() - b0; i++) begin
            chk(b_addr(b0 + i) == longint'(base + 4 * i), "R4", {tag, " beat address"},
                b_addr(b0 + i), base + 4 * i);
            chk(b_data(b0 + i) == longint'(32'h5A00_0000 + base + i), "R5", {tag, " beat data"},
                b_data(b0 + i), 32'h5A00_0000 + base + i);
        end
    endtask

    task automatic do_read(bit s, logic [AW-1:0] base, int bc, bit stall, string tag);
        int c0, b0, r0, held, guard, nsub;
        @(posedge clk); #1;
        sel = s; stall_en = stall;
        c0 = cmd_n(); b0 = beat_n(); r0 = rcnt; held = 0;
        nsub = (bc + cur_max() - 1) / cur_max();
        hb_read = 1'b1; hb_addr = base; hb_bc = HBC_W'(bc);
        forever begin @(negedge clk); if (!obs_wait) break; held++; end
        chk(cmd_n() - c0 == nsub - 1, "R7", {tag, " commands before release"}, cmd_n() - c0, nsub - 1);
        if (!stall && nsub == 1)
            chk(held == 0, "R1", {tag, " short read not held"}, held, 0);
        @(posedge clk); #1;
        hb_read = 1'b0;
        guard = 0;
        while (rcnt - r0 < bc && guard < 2000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
        chk(rcnt - r0 == bc, "R8", {tag, " returned beats"}, rcnt - r0, bc);
        chk_cmds(c0, base, bc, 1'b0, tag);
        for (int i = 0; i < bc && i < rcnt - r0; i++) begin
            logic [AW-1:0] a = base + 4 * i;
            chk(rbuf[(r0 + i) % 2048] == exp_word(a), "R8", {tag, " read data order"},
                rbuf[(r0 + i) % 2048], exp_word(a));
            chk(b_addr(b0 + i) == longint'(a), "R4", {tag, " read beat address"}, b_addr(b0 + i), a);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!ar0 && !aw0 && !ar1 && !aw1, "R10", "agent quiet after reset",
            {ar0, aw0, ar1, aw1}, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            exp0[i] = 32'hC0DE_0000 ^ (i * 7);
            exp1[i] = 32'hC0DE_0000 ^ (i * 7);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();                                      // R10
        do_write(1'b0, 32'h40,  3,   1'b0, "R1 short write");
        do_read (1'b0, 32'h40,  3,   1'b0, "R1 short read");
        do_read (1'b0, 32'h60,  4,   1'b0, "R1 full-size read");
        do_write(1'b0, 32'h100, 10,  1'b1, "R3 long write stalled");
        do_read (1'b0, 32'h100, 10,  1'b1, "R7 long read stalled");
        do_write(1'b0, 32'h200, 8,   1'b0, "R3 exact multiple write");
        do_read (1'b0, 32'h1F8, 9,   1'b0, "R8 read across written edge");
        do_write(1'b0, 32'h300, 128, 1'b1, "R4 max host write");
        do_read (1'b0, 32'h300, 128, 1'b1, "R4 max host read");
        do_write(1'b1, 32'h80,  5,   1'b1, "R9 single-word write");
        do_read (1'b1, 32'h80,  5,   1'b1, "R9 single-word read");
        do_read (1'b1, 32'h90,  1,   1'b0, "R9 one-word read");
        t_reset();                                      // R10 idle again
        chk(m0.viol == 0, "R2", "burst count cap, max 4", m0.viol, 0);
        chk(m1.viol == 0, "R2", "burst count cap, max 1", m1.viol, 0);
        chk(stall_err == 0, "R6", "host stalled with agent", stall_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule